// File: doc/BRIEF.md
# Programmable Watchdog Timer Controller

This block is a watchdog timer. Software controls it through one write-only control register on a simple memory-mapped write bus. The counter advances only on a slow timing tick, one pulse per quarter second, which is made outside the block. The register holds three things: an enable, a clear strobe and a 3-bit interval code. When the watchdog is enabled and the count reaches the selected interval, the block drives a reset request for a fixed number of clock cycles. The count then starts again from zero.

Software keeps the system alive by writing the clear bit before the interval runs out. The interval code selects 1 to 7 ticks, and code zero selects the longest period of 8 ticks. A new interval code restarts the count, so the new period takes effect at once. The clear bit is a strobe. It is never stored.

Top module: `wdt_guard`

## Requirements
- R1: After reset, rst_req is low, the watchdog is disabled and the interval code is 0.
- R2: Only a cycle with bus_wr high and bus_addr equal to CTRL_ADDR (default 12'hF18) writes the control register. Any other write has no effect.
- R3: Bit 7 of the written data is the enable. While it is 0, rst_req stays low and the tick count is held at zero, so a later enable starts from a full interval.
- R4: Bits 2:0 hold the interval code. A code N of 1 to 7 makes the N-th counted tick after a restart overflow the watchdog.
- R5: An interval code of 0 makes the 8th counted tick overflow the watchdog.
- R6: A write with bit 6 set restarts the count at zero. The bit is not stored, so counting continues normally afterwards.
- R7: A write whose bits 2:0 differ from the held code restarts the count. A write with the same code and bit 6 clear does not restart it.
- R8: rst_req rises at the clock edge that samples the overflowing tick and stays high for exactly PULSE_CYCLES (default 16) cycles.
- R9: Ticks during the reset request are ignored. After overflow the count restarts from zero, so the next request needs a full interval.
- R10: When a restarting write and a tick occur in the same cycle, the restart wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe of the register bus |
| bus_addr | input | ADDR_W (12) | Write address |
| bus_wdata | input | 8 | Write data: bit 7 enable, bit 6 clear, bits 2:0 interval code |
| tick | input | 1 | Single-cycle quarter-second timing pulse, synchronous to clk |
| rst_req | output | 1 | Reset request, high for PULSE_CYCLES cycles on overflow |

## Verification
A register write takes effect at the rising edge that samples bus_wr, including any restart it causes. An overflowing tick raises rst_req at the same edge that samples it. The request falls PULSE_CYCLES edges later. The bench drives inputs and samples rst_req on falling edges. It reads the result at the falling edge right after each tick, which is the first point where a new request can be seen. It measures the pulse width by counting falling edges while rst_req is high. Expected interval lengths come from the code value alone, with every code from 0 to 7 swept.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int DATA_W  = 8;
  localparam int EN_BIT  = 7;
  localparam int CLR_BIT = 6;
  localparam int CODE_W  = 3;
  localparam int CNT_W   = CODE_W + 1;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regif.sv
`timescale 1ns/1ps
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output wdt_ctrl_t         ctrl_q,
  output logic              restart
);
  logic      hit;
  wdt_ctrl_t ctrl_d;
  logic      ctrl_ce;

  always_comb begin
    hit     = bus_wr && (bus_addr == CTRL_ADDR);
    ctrl_ce = hit;
    ctrl_d.en   = bus_wdata[EN_BIT];
    ctrl_d.code = bus_wdata[CODE_W-1:0];
    restart = hit && (bus_wdata[CLR_BIT] || (bus_wdata[CODE_W-1:0] != ctrl_q.code));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  input  logic              tick,
  input  logic              busy,
  output logic              ovf,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] MAX_TICKS = CNT_W'(1 << CODE_W);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_d;
  logic             hold;
  logic             last;

  always_comb begin
    limit = (code == '0) ? MAX_TICKS : CNT_W'(code);
    hold  = !en || restart || busy;
    last  = (cnt_q == (limit - CNT_W'(1)));
    ovf   = !hold && tick && last;
    cnt_d = cnt_q;
    if (hold) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = last ? '0 : (cnt_q + CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES);

  logic [PW-1:0] left_q;
  logic [PW-1:0] left_d;

  always_comb begin
    left_d = left_q;
    if (fire) begin
      left_d = LOAD;
    end else if (left_q != '0) begin
      left_d = left_q - PW'(1);
    end
    active = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR    = 12'hF18,
  parameter int                PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              tick,
  output logic              rst_req
);
  logic [1:0]       rst_sync_q;
  logic             srst_n;
  wdt_ctrl_t        ctrl_q;
  logic             restart;
  logic             ovf;
  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  wdt_regif #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regif (
    .clk       (clk),
    .rst_n     (srst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .restart   (restart)
  );

  wdt_counter u_counter (
    .clk     (clk),
    .rst_n   (srst_n),
    .en      (ctrl_q.en),
    .code    (ctrl_q.code),
    .restart (restart),
    .tick    (tick),
    .busy    (busy),
    .ovf     (ovf),
    .cnt_q   (cnt_q)
  );

  wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (srst_n),
    .fire   (ovf),
    .active (busy)
  );

  assign rst_req = busy;
endmodule

// File: rtl/wdt_guard_chk.sv
`timescale 1ns/1ps
module wdt_guard_chk #(
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR    = 12'hF18,
  parameter int                PULSE_CYCLES = 16,
  parameter int                CNT_W        = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              tick,
  input logic              rst_req,
  input logic              en_q,
  input logic [2:0]        code_q,
  input logic              restart,
  input logic [CNT_W-1:0]  cnt_q
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (rst_req) begin
      hi_cnt <= hi_cnt + 16'd1;
    end else begin
      hi_cnt <= '0;
    end
  end

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (hi_cnt == 16'(PULSE_CYCLES)));

  // R8
  req_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(tick));

  // R3
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(en_q));

  // R2
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr != CTRL_ADDR)) |=> ($stable(en_q) && $stable(code_q)));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_q == '0));
endmodule

bind wdt_guard wdt_guard_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .PULSE_CYCLES(PULSE_CYCLES), .CNT_W(wdt_pkg::CNT_W)
) u_wdt_guard_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .tick     (tick),
  .rst_req  (rst_req),
  .en_q     (ctrl_q.en),
  .code_q   (ctrl_q.code),
  .restart  (restart),
  .cnt_q    (cnt_q)
);

// File: tb/test_wdt_guard.sv
`timescale 1ns/1ps
module test_wdt_guard;
  localparam int PULSE = 16;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        tick;
  logic        rst_req;

  int checks;
  int errors;

  wdt_guard #(.ADDR_W(12), .CTRL_ADDR(12'hF18), .PULSE_CYCLES(PULSE)) i_wdt_guard (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tick(tick), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input bit with_tick = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // n ticks; returns 1 if rst_req was seen after any of them
  task automatic ticks(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      one_tick();
      if (rst_req) seen = 1'b1;
    end
  endtask

  task automatic wait_idle();
    while (rst_req) @(negedge clk);
  endtask

  initial begin
    bit seen;
    int len;
    int lim;
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: request low after reset, disabled
    check(rst_req == 1'b0, "R1 reset", rst_req, 0);
    ticks(10, seen);
    check(!seen, "R1 disabled after reset", seen, 0);
    // R1/R5: enable only; reset code 0 means 8 ticks
    wr(12'hF18, 8'h80);
    ticks(7, seen);
    check(!seen, "R1 code0 early", seen, 0);
    one_tick();
    check(rst_req == 1'b1, "R1 code0 8th tick", rst_req, 1);
    wait_idle();
    wr(12'hF18, 8'h00);

    // R2: writes elsewhere ignored
    wr(12'hF10, 8'h81);
    ticks(10, seen);
    check(!seen, "R2 foreign address", seen, 0);

    // R4/R5/R8/R9 sweep of all codes
    for (int c = 0; c < 8; c++) begin
      lim = (c == 0) ? 8 : c;
      wr(12'hF18, 8'hC0 | 8'(c));
      ticks(lim - 1, seen);
      check(!seen, (c == 0) ? "R5 early" : "R4 early", seen, 0);
      one_tick();
      check(rst_req == 1'b1, (c == 0) ? "R5 overflow" : "R4 overflow", rst_req, 1);
      len = 1;
      for (int i = 1; i < 40; i++) begin
        @(negedge clk);
        tick = (i == 3);
        if (rst_req) len++;
        else break;
      end
      tick = 1'b0;
      check(len == PULSE, "R8 pulse width", len, PULSE);
      ticks(lim - 1, seen);
      check(!seen, "R9 restart after overflow", seen, 0);
      one_tick();
      check(rst_req == 1'b1, "R9 next overflow", rst_req, 1);
      wait_idle();
    end

    // R3: disable holds count at zero
    wr(12'hF18, 8'hC2);
    one_tick();
    wr(12'hF18, 8'h02);
    ticks(6, seen);
    check(!seen, "R3 disabled", seen, 0);
    wr(12'hF18, 8'h82);
    ticks(1, seen);
    check(!seen, "R3 count held at zero", seen, 0);
    one_tick();
    check(rst_req == 1'b1, "R3 re-enabled overflow", rst_req, 1);
    wait_idle();

    // R6: clear restarts, not stored
    wr(12'hF18, 8'hC4);
    ticks(3, seen);
    wr(12'hF18, 8'hC4);
    ticks(3, seen);
    check(!seen, "R6 clear restarts", seen, 0);
    one_tick();
    check(rst_req == 1'b1, "R6 clear not stored", rst_req, 1);
    wait_idle();

    // R7: new code restarts, same code without clear does not
    wr(12'hF18, 8'hC3);
    ticks(2, seen);
    wr(12'hF18, 8'h82);
    ticks(1, seen);
    check(!seen, "R7 new code restarts", seen, 0);
    one_tick();
    check(rst_req == 1'b1, "R7 new code period", rst_req, 1);
    wait_idle();
    wr(12'hF18, 8'hC3);
    ticks(2, seen);
    wr(12'hF18, 8'h83);
    one_tick();
    check(rst_req == 1'b1, "R7 same code keeps count", rst_req, 1);
    wait_idle();

    // R10: restart wins over simultaneous tick
    wr(12'hF18, 8'hC2);
    one_tick();
    wr(12'hF18, 8'hC2, 1'b1);
    ticks(1, seen);
    check(!seen, "R10 tick dropped on restart", seen, 0);
    one_tick();
    check(rst_req == 1'b1, "R10 overflow after restart", rst_req, 1);
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule